// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block is a single memory-to-memory DMA channel. It reads its work from a circular table of buffer descriptors in an on-chip descriptor RAM. Each descriptor names one source buffer, one destination buffer and a byte count. The channel copies the buffer one 32-bit word at a time, from ascending source addresses to ascending destination addresses. Each descriptor also carries its own flags, which decide whether an interrupt pulse or a done pulse is raised when that buffer finishes.

The channel has two modes, chosen by a configuration bit. In chained mode it walks through the table one descriptor after another. It clears each descriptor's ready flag as that descriptor completes, and it halts after the descriptor flagged last. In continuous mode it repeats the current descriptor until software issues a stop command or the external done input asserts. Configuration writes take effect only before the first start or while the stop-completed event bit is set.

The sequencer states are IDLE, RD_CTL, RD_CNT, RD_SRC, RD_DST, CAP_DST, XFER_RD, XFER_WR and DESC_DONE.
- IDLE→RD_CTL: on an accepted start.
- RD_CTL→RD_CNT→RD_SRC→RD_DST→CAP_DST: the descriptor fetch, one word per state.
- RD_CNT→IDLE: the descriptor is not ready.
- CAP_DST→XFER_RD: the byte count is non-zero. CAP_DST→DESC_DONE: the byte count is zero.
- XFER_RD→XFER_WR: a word is read.
- XFER_WR→XFER_RD: the write is accepted and more words remain. XFER_WR→DESC_DONE: the write is accepted and it was the final word.
- DESC_DONE→RD_CTL: the next descriptor, or the same descriptor in continuous mode. DESC_DONE→IDLE: the completed descriptor was flagged last.
- RD_CTL→IDLE and XFER_RD→IDLE: a halt is pending.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, busy, irq, done_pulse, mem_rd_en, mem_wr_en and dr_wr_en are all 0, and evt_flags reads 0.
- R2: A descriptor is four consecutive RAM words at offsets +0 (control), +1 (byte count in bits 15:0), +2 (source byte address) and +3 (destination byte address). The channel copies ceil(count/4) words, each read from src+4k and written to dst+4k for k counting up from 0. A count of 0 moves no data.
- R3: In chained mode (cfg_chain=1), each completed descriptor has its control word written back with bit 0 (ready) cleared and its other bits unchanged. The channel goes idle after completing a descriptor whose bit 1 (last) is set.
- R4: A descriptor whose ready bit (bit 0) is clear moves no data and sends the channel to idle.
- R5: In chained mode, a completed descriptor with bit 4 (wrap) set returns the descriptor pointer to the table base. Otherwise the pointer advances by 4 words.
- R6: In continuous mode (cfg_chain=0), the channel repeats the same descriptor, does not write its control word, and runs until a stop command or ext_done arrives.
- R7: cmd_stop halts the channel at the next word or descriptor boundary, returns busy to 0 and sets evt_flags bit 1 (stop-completed). It also sets that bit if the channel is already idle. A halt caused by ext_done leaves bit 1 unchanged.
- R8: evt_flags bit 0 (buffer-complete) is set when a descriptor completes. A 1 written on evt_clr[i] clears evt_flags[i].
- R9: irq is a one-cycle pulse when a descriptor with control bit 2 set completes. done_pulse is a one-cycle pulse when a descriptor with control bit 3 set completes.
- R10: A cfg_we write is accepted only before the first accepted start, or while evt_flags bit 1 is set. Otherwise it is ignored.
- R11: The descriptor table starts at RAM word {cfg_base[9:6], 4'b0000}. Bits 5:0 of cfg_base are ignored, so the table sits on a 64-byte boundary.
- R12: While mem_wr_rdy is low, mem_wr_en stays high with mem_wr_addr and mem_wr_data held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chain | input | 1 | Mode: 1 chained, 0 continuous |
| cfg_base | input | 10 | Table base byte pointer (low 6 bits ignored) |
| cmd_start | input | 1 | Start command strobe |
| cmd_stop | input | 1 | Stop command strobe |
| ext_done | input | 1 | External termination request |
| evt_clr | input | 2 | Write-one-to-clear for evt_flags |
| evt_flags | output | 2 | Bit 0 buffer-complete, bit 1 stop-completed |
| busy | output | 1 | Channel is not idle |
| irq | output | 1 | Interrupt pulse |
| done_pulse | output | 1 | Per-descriptor done pulse |
| dr_addr | output | 8 | Descriptor RAM word address |
| dr_rd_en | output | 1 | Descriptor RAM read (data valid next cycle) |
| dr_rdata | input | 32 | Descriptor RAM read data |
| dr_wr_en | output | 1 | Descriptor RAM write |
| dr_wdata | output | 32 | Descriptor RAM write data |
| mem_rd_en | output | 1 | Data memory read (data valid next cycle) |
| mem_rd_addr | output | 16 | Data memory read byte address |
| mem_rd_data | input | 32 | Data memory read data |
| mem_wr_en | output | 1 | Data memory write request |
| mem_wr_addr | output | 16 | Data memory write byte address |
| mem_wr_data | output | 32 | Data memory write data |
| mem_wr_rdy | input | 1 | Write accepted this cycle |

## Verification
A wrong descriptor pointer shows up within a few cycles. The next write goes to a destination that does not match the descriptor expected from the wrap, advance or base rules, and the scoreboard catches it on the first word. A corrupt count or a stale read-hold register shows up as a missing, extra or mis-valued write before the descriptor completes. A sequencer that fails to halt or to re-fetch shows up as writes after idle, as a ready bit left set or wrongly cleared in the RAM image, or as wrong event bits once busy falls.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
    localparam int CTL_READY = 0;
    localparam int CTL_LAST  = 1;
    localparam int CTL_IRQ   = 2;
    localparam int CTL_DONE  = 3;
    localparam int CTL_WRAP  = 4;

    localparam int EVT_BUF  = 0;
    localparam int EVT_STOP = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTL,
        ST_RD_CNT,
        ST_RD_SRC,
        ST_RD_DST,
        ST_CAP_DST,
        ST_XFER_RD,
        ST_XFER_WR,
        ST_DESC_DONE
    } seq_state_e;
endpackage

// File: rtl/dmaseq_cfg.sv
module dmaseq_cfg #(
    parameter int RAM_AW = 8,
    parameter int PTR_W  = RAM_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_chain,
    input  logic [PTR_W-1:0]  cfg_base,
    input  logic              start_acc,
    input  logic              stop_flag,
    output logic              chain_q,
    output logic [RAM_AW-1:0] base_q
);
    localparam int ALIGN_BITS = 6;
    localparam int WORD_SHIFT = 2;
    localparam int LOW_ZERO   = ALIGN_BITS - WORD_SHIFT;

    logic started_once;
    logic unlocked;

    assign unlocked = !started_once || stop_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_once <= 1'b0;
            chain_q      <= 1'b1;
            base_q       <= '0;
        end else begin
            if (start_acc) begin
                started_once <= 1'b1;
            end
            if (cfg_we && unlocked) begin
                chain_q <= cfg_chain;
                base_q  <= {cfg_base[PTR_W-1:ALIGN_BITS], {LOW_ZERO{1'b0}}};
            end
        end
    end

    // R10: a locked configuration write leaves the stored parameters untouched
    assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !unlocked) |=> ($stable(base_q) && $stable(chain_q)));
endmodule

// File: rtl/dmaseq_evt.sv
module dmaseq_evt
    import dmaseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_buf,
    input  logic       set_stop,
    input  logic       irq_req,
    input  logic       done_req,
    input  logic [1:0] evt_clr,
    output logic [1:0] evt_flags,
    output logic       irq,
    output logic       done_pulse
);
    logic [1:0] set_vec;

    assign set_vec = {set_stop, set_buf};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_flags  <= '0;
            irq        <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            evt_flags  <= (evt_flags & ~evt_clr) | set_vec;
            irq        <= irq_req;
            done_pulse <= done_req;
        end
    end

    // R9: completions are several cycles apart, so irq never stays high
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: a write-one clear without a simultaneous set empties the bit
    assert_clear_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr[EVT_BUF] && !set_buf) |=> !evt_flags[EVT_BUF]);
endmodule

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
    import dmaseq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int RAM_AW = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              ext_done,
    input  logic              chain,
    input  logic [RAM_AW-1:0] base,
    output logic [RAM_AW-1:0] dr_addr,
    output logic              dr_rd_en,
    input  logic [DW-1:0]     dr_rdata,
    output logic              dr_wr_en,
    output logic [DW-1:0]     dr_wdata,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [DW-1:0]     mem_rd_data,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [DW-1:0]     mem_wr_data,
    input  logic              mem_wr_rdy,
    output logic              busy,
    output logic              start_acc,
    output logic              set_buf,
    output logic              set_stop,
    output logic              irq_req,
    output logic              done_req
);
    localparam int WORD_BYTES = DW / 8;
    localparam int DESC_WORDS = 4;

    seq_state_e        state, nxt;
    logic [RAM_AW-1:0] ptr;
    logic [DW-1:0]     ctl_word;
    logic [CNT_W-1:0]  cnt;
    logic [AW-1:0]     src, dst;
    logic [DW-1:0]     hold;
    logic              hold_vld;
    logic              stop_pend, ext_pend;
    logic              halt_now;

    assign halt_now = stop_pend || cmd_stop || ext_pend || ext_done;
    assign busy     = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt         = state;
        dr_addr     = ptr;
        dr_rd_en    = 1'b0;
        dr_wr_en    = 1'b0;
        dr_wdata    = ctl_word & ~(DW'(1) << CTL_READY);
        mem_rd_en   = 1'b0;
        mem_rd_addr = src;
        mem_wr_en   = 1'b0;
        mem_wr_addr = dst;
        mem_wr_data = hold_vld ? hold : mem_rd_data;
        start_acc   = 1'b0;
        set_buf     = 1'b0;
        irq_req     = 1'b0;
        done_req    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_start && !cmd_stop) begin
                    start_acc = 1'b1;
                    nxt       = ST_RD_CTL;
                end
            end
            ST_RD_CTL: begin
                if (halt_now) begin
                    nxt = ST_IDLE;
                end else begin
                    dr_rd_en = 1'b1;
                    nxt      = ST_RD_CNT;
                end
            end
            ST_RD_CNT: begin
                if (!dr_rdata[CTL_READY]) begin
                    nxt = ST_IDLE;
                end else begin
                    dr_rd_en = 1'b1;
                    dr_addr  = ptr + RAM_AW'(1);
                    nxt      = ST_RD_SRC;
                end
            end
            ST_RD_SRC: begin
                dr_rd_en = 1'b1;
                dr_addr  = ptr + RAM_AW'(2);
                nxt      = ST_RD_DST;
            end
            ST_RD_DST: begin
                dr_rd_en = 1'b1;
                dr_addr  = ptr + RAM_AW'(3);
                nxt      = ST_CAP_DST;
            end
            ST_CAP_DST: begin
                nxt = (cnt == '0) ? ST_DESC_DONE : ST_XFER_RD;
            end
            ST_XFER_RD: begin
                if (halt_now) begin
                    nxt = ST_IDLE;
                end else begin
                    mem_rd_en = 1'b1;
                    nxt       = ST_XFER_WR;
                end
            end
            ST_XFER_WR: begin
                mem_wr_en = 1'b1;
                if (mem_wr_rdy) begin
                    nxt = (cnt <= CNT_W'(WORD_BYTES)) ? ST_DESC_DONE : ST_XFER_RD;
                end
            end
            ST_DESC_DONE: begin
                set_buf  = 1'b1;
                irq_req  = ctl_word[CTL_IRQ];
                done_req = ctl_word[CTL_DONE];
                if (chain) begin
                    dr_wr_en = 1'b1;
                    nxt      = ctl_word[CTL_LAST] ? ST_IDLE : ST_RD_CTL;
                end else begin
                    nxt = ST_RD_CTL;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        set_stop = (nxt == ST_IDLE) && (stop_pend || cmd_stop);
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            ctl_word  <= '0;
            cnt       <= '0;
            src       <= '0;
            dst       <= '0;
            hold      <= '0;
            hold_vld  <= 1'b0;
            stop_pend <= 1'b0;
            ext_pend  <= 1'b0;
        end else begin
            if (nxt == ST_IDLE) begin
                stop_pend <= 1'b0;
                ext_pend  <= 1'b0;
            end else begin
                stop_pend <= stop_pend || cmd_stop;
                ext_pend  <= ext_pend || ext_done;
            end
            unique case (state)
                ST_IDLE:    if (start_acc) ptr <= base;
                ST_RD_CNT:  ctl_word <= dr_rdata;
                ST_RD_SRC:  cnt <= dr_rdata[CNT_W-1:0];
                ST_RD_DST:  src <= dr_rdata[AW-1:0];
                ST_CAP_DST: dst <= dr_rdata[AW-1:0];
                ST_XFER_RD: hold_vld <= 1'b0;
                ST_XFER_WR: begin
                    if (mem_wr_rdy) begin
                        src <= src + AW'(WORD_BYTES);
                        dst <= dst + AW'(WORD_BYTES);
                        cnt <= cnt - CNT_W'(WORD_BYTES);
                    end else if (!hold_vld) begin
                        hold     <= mem_rd_data;
                        hold_vld <= 1'b1;
                    end
                end
                ST_DESC_DONE: begin
                    if (chain && !ctl_word[CTL_LAST]) begin
                        ptr <= ctl_word[CTL_WRAP] ? base : ptr + RAM_AW'(DESC_WORDS);
                    end
                end
                default: ;
            endcase
        end
    end

    // R12: a stalled write keeps its request, address and data
    assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !mem_wr_rdy) |=> (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    // R2: a word is never read and written in the same cycle
    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    // R3: descriptor write-back never overlaps data traffic
    assert_wb_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dr_wr_en |-> (!mem_wr_en && !mem_rd_en && !dr_rd_en));
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
    import dmaseq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int RAM_AW = 8,
    parameter int CNT_W  = 16,
    parameter int PTR_W  = RAM_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_chain,
    input  logic [PTR_W-1:0]  cfg_base,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              ext_done,
    input  logic [1:0]        evt_clr,
    output logic [1:0]        evt_flags,
    output logic              busy,
    output logic              irq,
    output logic              done_pulse,
    output logic [RAM_AW-1:0] dr_addr,
    output logic              dr_rd_en,
    input  logic [DW-1:0]     dr_rdata,
    output logic              dr_wr_en,
    output logic [DW-1:0]     dr_wdata,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [DW-1:0]     mem_rd_data,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [DW-1:0]     mem_wr_data,
    input  logic              mem_wr_rdy
);
    logic              chain_q;
    logic [RAM_AW-1:0] base_q;
    logic              start_acc, set_buf, set_stop, irq_req, done_req;

    dmaseq_cfg #(.RAM_AW(RAM_AW), .PTR_W(PTR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_chain (cfg_chain),
        .cfg_base  (cfg_base),
        .start_acc (start_acc),
        .stop_flag (evt_flags[EVT_STOP]),
        .chain_q   (chain_q),
        .base_q    (base_q)
    );

    dmaseq_fsm #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .ext_done    (ext_done),
        .chain       (chain_q),
        .base        (base_q),
        .dr_addr     (dr_addr),
        .dr_rd_en    (dr_rd_en),
        .dr_rdata    (dr_rdata),
        .dr_wr_en    (dr_wr_en),
        .dr_wdata    (dr_wdata),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_wr_rdy  (mem_wr_rdy),
        .busy        (busy),
        .start_acc   (start_acc),
        .set_buf     (set_buf),
        .set_stop    (set_stop),
        .irq_req     (irq_req),
        .done_req    (done_req)
    );

    dmaseq_evt u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_buf    (set_buf),
        .set_stop   (set_stop),
        .irq_req    (irq_req),
        .done_req   (done_req),
        .evt_clr    (evt_clr),
        .evt_flags  (evt_flags),
        .irq        (irq),
        .done_pulse (done_pulse)
    );

    // R7: stop-completed rises only once the channel is idle
    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[EVT_STOP]) |-> !busy);
    // R3: descriptor write-back only happens in chained mode
    assert_wb_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dr_wr_en |-> chain_q);
endmodule

// File: tb/test_desc_dma_chan.sv
module test_desc_dma_chan;
    localparam int RDY = 1, LST = 2, IRQ = 4, DNE = 8, WRP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_chain = 1'b1;
    logic [9:0]  cfg_base = '0;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0, ext_done = 1'b0;
    logic [1:0]  evt_clr = '0;
    logic [1:0]  evt_flags;
    logic        busy, irq, done_pulse;
    logic [7:0]  dr_addr;
    logic        dr_rd_en, dr_wr_en;
    logic [31:0] dr_rdata = '0, dr_wdata;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data = '0, mem_wr_data;
    logic        mem_wr_rdy;

    logic [31:0] ram  [0:255];
    logic [31:0] dmem [0:1023];
    logic [15:0] exp_addr_q[$];
    logic [31:0] exp_data_q[$];
    int          n_checks = 0, n_fails = 0, irq_cnt = 0, done_cnt = 0, cyc = 0;
    logic [7:0]  lfsr = 8'hA5;
    logic        stall_en = 1'b0;
    logic        finished = 1'b0;

    always #4 clk = ~clk;

    desc_dma_chan i_desc_dma_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chain(cfg_chain), .cfg_base(cfg_base),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .ext_done(ext_done), .evt_clr(evt_clr),
        .evt_flags(evt_flags), .busy(busy), .irq(irq), .done_pulse(done_pulse),
        .dr_addr(dr_addr), .dr_rd_en(dr_rd_en), .dr_rdata(dr_rdata), .dr_wr_en(dr_wr_en),
        .dr_wdata(dr_wdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_rdy(mem_wr_rdy)
    );

    function automatic logic [31:0] pat(input logic [15:0] a);
        return {a ^ 16'hC0DE, ~a};
    endfunction

    assign mem_wr_rdy = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;

    // memory models
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (dr_rd_en) dr_rdata <= ram[dr_addr];
        if (dr_wr_en) ram[dr_addr] <= dr_wdata;
        if (mem_rd_en) mem_rd_data <= dmem[mem_rd_addr[11:2]];
        if (mem_wr_en && mem_wr_rdy) dmem[mem_wr_addr[11:2]] <= mem_wr_data;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (irq) irq_cnt++;
        if (done_pulse) done_cnt++;
        if (rst_n && mem_wr_en && mem_wr_rdy) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R2 unexpected write", {16'h0, mem_wr_addr}, 32'h0);
            end else begin
                logic [15:0] ea;
                logic [31:0] ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                check(mem_wr_addr == ea && mem_wr_data == ed, "R2 write addr/data",
                      {mem_wr_addr, mem_wr_data[15:0]}, {ea, ed[15:0]});
            end
        end
        if (cyc == 150000 && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic expect_copy(input logic [15:0] s, input logic [15:0] d, input int cnt);
        for (int k = 0; k < (cnt + 3) / 4; k++) begin
            exp_addr_q.push_back(d + 16'(4 * k));
            exp_data_q.push_back(pat(s + 16'(4 * k)));
        end
    endtask

    task automatic put_desc(input int w, input logic [31:0] ctl, input int cnt,
                            input logic [15:0] s, input logic [15:0] d);
        ram[w] = ctl; ram[w + 1] = cnt; ram[w + 2] = {16'h0, s}; ram[w + 3] = {16'h0, d};
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: cmd_start = 1'b1;
            1: cmd_stop = 1'b1;
            default: ext_done = 1'b1;
        endcase
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0; ext_done = 1'b0;
    endtask

    task automatic cfg_write(input logic ch, input logic [9:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chain = ch; cfg_base = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_evt(input logic [1:0] m);
        @(negedge clk);
        evt_clr = m;
        @(negedge clk);
        evt_clr = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) dmem[i] = pat(16'(i * 4));
        for (int i = 0; i < 256; i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !irq && !done_pulse && !mem_wr_en && !mem_rd_en && !dr_wr_en && evt_flags == 0,
              "R1 reset outputs", {busy, irq, mem_wr_en, evt_flags}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // chained walk with stalls, zero count, irq/done flags
        cfg_write(1'b1, 10'h000);
        put_desc(0, RDY, 12, 16'h0100, 16'h0800);
        put_desc(4, RDY | IRQ, 8, 16'h0200, 16'h0900);
        put_desc(8, RDY | LST | DNE, 0, 16'h0300, 16'h0A00);
        expect_copy(16'h0100, 16'h0800, 12);
        expect_copy(16'h0200, 16'h0900, 8);
        stall_en = 1'b1;
        strobe(0);
        check(busy, "R3 busy after start", busy, 1);
        wait_idle();
        stall_en = 1'b0;
        check(!busy, "R3 halts after last", busy, 0);
        check(exp_addr_q.size() == 0, "R2 all words written R12", exp_addr_q.size(), 0);
        check(ram[0] == 0, "R3 ready cleared d0", ram[0], 0);
        check(ram[4] == IRQ, "R3 ready cleared d1 other bits kept", ram[4], IRQ);
        check(ram[8] == (LST | DNE), "R2 zero-count desc completed", ram[8], LST | DNE);
        check(irq_cnt == 1, "R9 one irq pulse", irq_cnt, 1);
        check(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
        check(evt_flags == 2'b01, "R8 buffer-complete set", evt_flags, 1);
        clear_evt(2'b01);
        check(evt_flags == 2'b00, "R8 write-one clear", evt_flags, 0);

        // R10 locked configuration write is ignored
        put_desc(64, RDY | WRP, 4, 16'h0180, 16'h0880);
        put_desc(68, RDY | LST, 4, 16'h01C0, 16'h08C0);
        cfg_write(1'b1, 10'h12C);
        put_desc(0, RDY | LST, 4, 16'h0140, 16'h0840);
        expect_copy(16'h0140, 16'h0840, 4);
        strobe(0);
        wait_idle();
        check(exp_addr_q.size() == 0, "R10 old base still used", exp_addr_q.size(), 0);
        check(ram[64] == (RDY | WRP), "R10 new table untouched", ram[64], RDY | WRP);
        clear_evt(2'b01);

        // R7 stop while idle; R10 unlocked; R11 base low bits ignored; R5 wrap; R4 reuse not ready
        strobe(1);
        @(negedge clk);
        check(evt_flags == 2'b10, "R7 stop while idle sets stop-completed", evt_flags, 2);
        cfg_write(1'b1, 10'h12C);
        clear_evt(2'b10);
        expect_copy(16'h0180, 16'h0880, 4);
        strobe(0);
        wait_idle();
        check(exp_addr_q.size() == 0, "R11 table at aligned base", exp_addr_q.size(), 0);
        check(ram[64] == WRP, "R5 wrap desc ready cleared", ram[64], WRP);
        check(ram[68] == (RDY | LST), "R5 wrap skipped next desc", ram[68], RDY | LST);
        clear_evt(2'b01);

        // R4 not-ready first descriptor
        strobe(0);
        wait_idle();
        check(!busy && evt_flags == 2'b00, "R4 not-ready desc no completion", evt_flags, 0);

        // R6 continuous mode, stopped by command
        strobe(1);
        cfg_write(1'b0, 10'h080);
        clear_evt(2'b11);
        put_desc(32, RDY | IRQ, 8, 16'h0240, 16'h0940);
        for (int r = 0; r < 60; r++) expect_copy(16'h0240, 16'h0940, 8);
        irq_cnt = 0;
        strobe(0);
        for (int i = 0; i < 5000 && irq_cnt < 3; i++) @(negedge clk);
        check(busy, "R6 still running after 3 buffers", busy, 1);
        strobe(1);
        wait_idle();
        exp_addr_q.delete(); exp_data_q.delete();
        check(!busy, "R7 stop halts channel", busy, 0);
        check(evt_flags[1], "R7 stop-completed set", evt_flags, 2'b11);
        check(irq_cnt >= 3, "R6 repeated completions", irq_cnt, 3);
        check(ram[32] == (RDY | IRQ), "R6 descriptor not written", ram[32], RDY | IRQ);

        // R7 external done terminates without stop-completed
        clear_evt(2'b11);
        for (int r = 0; r < 60; r++) expect_copy(16'h0240, 16'h0940, 8);
        irq_cnt = 0;
        strobe(0);
        for (int i = 0; i < 5000 && irq_cnt < 2; i++) @(negedge clk);
        strobe(2);
        wait_idle();
        exp_addr_q.delete(); exp_data_q.delete();
        check(!busy, "R6 ext_done halts channel", busy, 0);
        check(!evt_flags[1], "R7 ext_done leaves stop bit clear", evt_flags, 2'b01);
        repeat (20) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule